// File: doc/BRIEF.md
# Coprocessor Deferred Exception Reporting Unit

This block keeps the exception records of a floating-point coprocessor that runs beside a host CPU. Each accepted waiting-class coprocessor instruction leaves its address (prefix bytes included), its opcode and, when it has a memory operand, the operand address in three pointer registers. The arithmetic datapath reports exception conditions as a six-bit vector. The block checks that vector against the mask bits of the control word and records the result in sticky status flags, a summary error bit and an ERROR output to the host.

The error is not reported when it happens. It is reported when the host next offers a waiting-class coprocessor instruction, which includes the no-operation instruction used to force out a pending error. That instruction is refused and a one-cycle trap pulse asks the host to enter its handler. The non-waiting instructions (initialize, clear exceptions, store status, store environment, save state) are always accepted. While an error is pending the pointers stay frozen, so the handler reads the faulting instruction's addresses. A load port stands in for environment restore.

The instruction input is a valid/ready interface. `ins_ready` is low only while the summary error is set and the offered instruction is of waiting class. In that cycle no transfer takes place and the host does not keep the instruction pending. It takes the trap and reissues the instruction after the handler has cleared the error. All other pins are plain level or pulse signals.

Top module: `cop_fault_unit`

## Requirements
- R1: An accepted instruction of waiting class (kind codes 0 arithmetic, 1 no-operation, 7 reserved) loads `ip_o` from `ins_addr` and `op_o` from `ins_opcode` on the next cycle.
- R2: That same capture loads `dp_o` from `ins_opnd` only when `ins_has_mem` is 1. Otherwise `dp_o` keeps its value.
- R3: A pulse on `exc_valid` ORs `exc_cond` into `flags_o` on the next cycle, whatever the mask. The flags are sticky. Bit order: 0 invalid, 1 denormal, 2 divide by zero, 3 overflow, 4 underflow, 5 precision.
- R4: When `exc_cond & ~mask_o` is nonzero, `es_o` and `error_o` go to 1 on the next cycle. A condition that is fully masked changes only the flags.
- R5: `cause_o` holds the index of the lowest-numbered (highest-precedence) unmasked condition from the event that set `es_o`. Later events do not change it, and it reads 7 while `es_o` is 0.
- R6: While `es_o` is 1, an offered waiting-class instruction sees `ins_ready` low in the same cycle and produces a one-cycle `trap_o` pulse on the next cycle. The no-operation instruction counts as waiting class.
- R7: Non-waiting kinds (2 initialize, 3 clear exceptions, 4 store status, 5 store environment, 6 save state) are always accepted, never cause `trap_o`, and never change the pointers.
- R8: While `es_o` is 1, the pointers change only through the load port.
- R9: An accepted initialize or clear-exceptions instruction zeroes `flags_o`, `es_o` and `error_o` and sets `cause_o` to 7 on the next cycle. It takes priority over an exception in the same cycle.
- R10: Reset and initialize set all six bits of `mask_o`. Reset also zeroes the flags, the error state and the pointers.
- R11: A pulse on `cw_wr` loads `mask_o` from `cw_mask` on the next cycle. Initialize in the same cycle wins.
- R12: A pulse on `ptr_ld` loads all three pointers from the load inputs on the next cycle. It takes priority over a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ins_valid | input | 1 | Instruction offered |
| ins_ready | output | 1 | Instruction accepted this cycle |
| ins_kind | input | 3 | Instruction class code |
| ins_addr | input | AW | Instruction address, prefixes included |
| ins_has_mem | input | 1 | Instruction has a memory operand |
| ins_opnd | input | AW | Memory operand address |
| ins_opcode | input | OW | Opcode |
| exc_valid | input | 1 | Datapath exception report |
| exc_cond | input | 6 | Exception conditions |
| cw_wr | input | 1 | Control-word mask write |
| cw_mask | input | 6 | New mask bits |
| ptr_ld | input | 1 | Pointer restore |
| ld_ip | input | AW | Restored instruction pointer |
| ld_dp | input | AW | Restored data pointer |
| ld_op | input | OW | Restored opcode |
| ip_o | output | AW | Instruction pointer |
| dp_o | output | AW | Data pointer |
| op_o | output | OW | Opcode register |
| flags_o | output | 6 | Sticky exception flags |
| mask_o | output | 6 | Mask bits |
| es_o | output | 1 | Summary error bit |
| error_o | output | 1 | ERROR to host |
| cause_o | output | 3 | Highest-precedence unmasked cause |
| trap_o | output | 1 | Trap request pulse |

## Verification
The assertions assume that the datapath never reports an exception in the same cycle as an instruction is accepted. A report always belongs to an instruction that has already been latched, so a capture and an error never collide. The stimulus holds to this by giving each random cycle exactly one action: an instruction, a report, a mask write or a restore. Only the directed cases combine a clear with a report, which is an allowed pairing. Clear and initialize are made rare, so that long pending-error stretches can build up and exercise the trap and the frozen pointers.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
  localparam int NEXC = 6;
  localparam int CAUSE_W = $clog2(NEXC + 1);

  typedef enum logic [2:0] {
    K_ARITH = 3'd0,
    K_NOP   = 3'd1,
    K_INIT  = 3'd2,
    K_CLEX  = 3'd3,
    K_STSW  = 3'd4,
    K_STENV = 3'd5,
    K_SAVE  = 3'd6,
    K_RSVD  = 3'd7
  } ins_kind_e;

  function automatic logic kind_waits(input logic [2:0] k);
    return !(k inside {K_INIT, K_CLEX, K_STSW, K_STENV, K_SAVE});
  endfunction
endpackage

// File: rtl/cfu_prio_enc.sv
module cfu_prio_enc #(
  parameter int N  = 6,
  parameter int CW = 3
) (
  input  logic [N-1:0]  req,
  output logic [CW-1:0] idx
);
  always_comb begin
    idx = {CW{1'b1}};
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = CW'(i);
    end
  end
endmodule

// File: rtl/cfu_issue_gate.sv
module cfu_issue_gate (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ins_valid,
  input  logic [2:0] ins_kind,
  input  logic       es,
  output logic       ins_ready,
  output logic       cap,
  output logic       clr,
  output logic       init,
  output logic       trap
);
  import cfu_pkg::*;
  logic waits, acc;

  assign waits     = kind_waits(ins_kind);
  assign ins_ready = !(waits && es);
  assign acc       = ins_valid && ins_ready;
  assign cap       = acc && waits;
  assign init      = acc && (ins_kind == K_INIT);
  assign clr       = acc && (ins_kind == K_CLEX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trap <= 1'b0;
    else        trap <= ins_valid && waits && es;
  end

  assert_exempt_no_trap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !waits) |=> !trap);
  assert_trap_needs_error_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !es |=> !trap);
endmodule

// File: rtl/cfu_ptr_regs.sv
module cfu_ptr_regs #(
  parameter int AW = 20,
  parameter int OW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          es,
  input  logic          cap,
  input  logic          cap_mem,
  input  logic [AW-1:0] cap_ip,
  input  logic [AW-1:0] cap_dp,
  input  logic [OW-1:0] cap_op,
  input  logic          ld,
  input  logic [AW-1:0] ld_ip,
  input  logic [AW-1:0] ld_dp,
  input  logic [OW-1:0] ld_op,
  output logic [AW-1:0] ip,
  output logic [AW-1:0] dp,
  output logic [OW-1:0] op
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip <= '0;
      dp <= '0;
      op <= '0;
    end else if (ld) begin
      ip <= ld_ip;
      dp <= ld_dp;
      op <= ld_op;
    end else if (cap) begin
      ip <= cap_ip;
      op <= cap_op;
      if (cap_mem) dp <= cap_dp;
    end
  end

  assert_ptr_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (es && !ld) |=> ($stable(ip) && $stable(dp) && $stable(op)));
  assert_dp_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !(cap && cap_mem)) |=> $stable(dp));
endmodule

// File: rtl/cfu_exc_status.sv
module cfu_exc_status #(
  parameter int N  = 6,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exc_valid,
  input  logic [N-1:0]  exc_cond,
  input  logic          clr,
  input  logic          init,
  input  logic          cw_wr,
  input  logic [N-1:0]  cw_mask,
  output logic [N-1:0]  flags,
  output logic [N-1:0]  mask,
  output logic          es,
  output logic          err,
  output logic [CW-1:0] cause
);
  localparam logic [CW-1:0] NONE = {CW{1'b1}};
  logic [N-1:0]  unm;
  logic [CW-1:0] enc;
  logic          wipe, hit;

  assign wipe = clr || init;
  assign unm  = exc_valid ? (exc_cond & ~mask) : '0;
  assign hit  = |unm;

  cfu_prio_enc #(.N(N), .CW(CW)) u_enc (.req(unm), .idx(enc));

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      flags[g] <= 1'b0;
      else if (wipe)                   flags[g] <= 1'b0;
      else if (exc_valid && exc_cond[g]) flags[g] <= 1'b1;
    end
    assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[g] && !wipe) |=> flags[g]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mask[g] <= 1'b1;
      else if (init)   mask[g] <= 1'b1;
      else if (cw_wr)  mask[g] <= cw_mask[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      es    <= 1'b0;
      err   <= 1'b0;
      cause <= NONE;
    end else if (wipe) begin
      es    <= 1'b0;
      err   <= 1'b0;
      cause <= NONE;
    end else if (hit) begin
      es  <= 1'b1;
      err <= 1'b1;
      if (!es) cause <= enc;
    end
  end

  assert_wipe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (flags == '0 && !es && !err));
  assert_masked_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!es && !wipe && (!exc_valid || ((exc_cond & ~mask) == '0))) |=> !es);
  assert_init_masks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (&mask));
  assert_cause_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (es && !wipe) |=> $stable(cause));
  assert_err_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    es == err);
endmodule

// File: rtl/cop_fault_unit.sv
module cop_fault_unit #(
  parameter int AW = 20,
  parameter int OW = 11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ins_valid,
  output logic                     ins_ready,
  input  logic [2:0]               ins_kind,
  input  logic [AW-1:0]            ins_addr,
  input  logic                     ins_has_mem,
  input  logic [AW-1:0]            ins_opnd,
  input  logic [OW-1:0]            ins_opcode,
  input  logic                     exc_valid,
  input  logic [cfu_pkg::NEXC-1:0] exc_cond,
  input  logic                     cw_wr,
  input  logic [cfu_pkg::NEXC-1:0] cw_mask,
  input  logic                     ptr_ld,
  input  logic [AW-1:0]            ld_ip,
  input  logic [AW-1:0]            ld_dp,
  input  logic [OW-1:0]            ld_op,
  output logic [AW-1:0]            ip_o,
  output logic [AW-1:0]            dp_o,
  output logic [OW-1:0]            op_o,
  output logic [cfu_pkg::NEXC-1:0] flags_o,
  output logic [cfu_pkg::NEXC-1:0] mask_o,
  output logic                     es_o,
  output logic                     error_o,
  output logic [cfu_pkg::CAUSE_W-1:0] cause_o,
  output logic                     trap_o
);
  import cfu_pkg::*;
  logic cap, clr, init;

  cfu_issue_gate u_gate (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_kind(ins_kind),
    .es(es_o), .ins_ready(ins_ready), .cap(cap), .clr(clr), .init(init),
    .trap(trap_o)
  );

  cfu_ptr_regs #(.AW(AW), .OW(OW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .es(es_o), .cap(cap), .cap_mem(ins_has_mem),
    .cap_ip(ins_addr), .cap_dp(ins_opnd), .cap_op(ins_opcode),
    .ld(ptr_ld), .ld_ip(ld_ip), .ld_dp(ld_dp), .ld_op(ld_op),
    .ip(ip_o), .dp(dp_o), .op(op_o)
  );

  cfu_exc_status #(.N(NEXC), .CW(CAUSE_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_cond(exc_cond),
    .clr(clr), .init(init), .cw_wr(cw_wr), .cw_mask(cw_mask),
    .flags(flags_o), .mask(mask_o), .es(es_o), .err(error_o), .cause(cause_o)
  );
endmodule

// File: tb/cop_fault_unit_bench.sv
module cop_fault_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int OW = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_valid, ins_ready, ins_has_mem, exc_valid, cw_wr, ptr_ld;
  logic [2:0] ins_kind;
  logic [AW-1:0] ins_addr, ins_opnd, ld_ip, ld_dp, ip_o, dp_o;
  logic [OW-1:0] ins_opcode, ld_op, op_o;
  logic [5:0] exc_cond, cw_mask, flags_o, mask_o;
  logic es_o, error_o, trap_o;
  logic [2:0] cause_o;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [AW-1:0] m_ip, m_dp;
  logic [OW-1:0] m_op;
  logic [5:0] m_flags, m_mask;
  logic m_es, m_trap;
  logic [2:0] m_cause;

  always #(CLK_PERIOD/2) clk = ~clk;

  cop_fault_unit #(.AW(AW), .OW(OW)) u_cop_fault_unit (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_kind(ins_kind), .ins_addr(ins_addr), .ins_has_mem(ins_has_mem),
    .ins_opnd(ins_opnd), .ins_opcode(ins_opcode), .exc_valid(exc_valid),
    .exc_cond(exc_cond), .cw_wr(cw_wr), .cw_mask(cw_mask), .ptr_ld(ptr_ld),
    .ld_ip(ld_ip), .ld_dp(ld_dp), .ld_op(ld_op), .ip_o(ip_o), .dp_o(dp_o),
    .op_o(op_o), .flags_o(flags_o), .mask_o(mask_o), .es_o(es_o),
    .error_o(error_o), .cause_o(cause_o), .trap_o(trap_o)
  );

  function automatic logic waits(input logic [2:0] k);
    return !(k >= 3'd2 && k <= 3'd6);
  endfunction

  function automatic logic [2:0] first_set(input logic [5:0] v);
    for (int i = 0; i < 6; i++) if (v[i]) return 3'(i);
    return 3'd7;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ins_valid = 0; ins_kind = 0; ins_addr = 0; ins_has_mem = 0; ins_opnd = 0;
    ins_opcode = 0; exc_valid = 0; exc_cond = 0; cw_wr = 0; cw_mask = 0;
    ptr_ld = 0; ld_ip = 0; ld_dp = 0; ld_op = 0;
  endtask

  task automatic check_all();
    chk("R1/R8/R12 ip", 32'(ip_o), 32'(m_ip));
    chk("R1/R8/R12 op", 32'(op_o), 32'(m_op));
    chk("R2/R12 dp", 32'(dp_o), 32'(m_dp));
    chk("R3/R9 flags", 32'(flags_o), 32'(m_flags));
    chk("R10/R11 mask", 32'(mask_o), 32'(m_mask));
    chk("R4/R9 es", 32'(es_o), 32'(m_es));
    chk("R4/R9 error", 32'(error_o), 32'(m_es));
    chk("R5 cause", 32'(cause_o), 32'(m_cause));
    chk("R6/R7 trap", 32'(trap_o), 32'(m_trap));
  endtask

  // inputs already set after a falling edge
  task automatic tick();
    logic acc, wt, clr, init;
    logic [5:0] unm;
    #1;
    wt = ins_valid && waits(ins_kind);
    chk("R6/R7 ready", 32'(ins_ready), 32'(!(waits(ins_kind) && m_es)));
    acc = ins_valid && !(waits(ins_kind) && m_es);
    init = acc && ins_kind == 3'd2;
    clr = acc && (ins_kind == 3'd3 || init);
    unm = exc_valid ? (exc_cond & ~m_mask) : 6'd0;
    if (ptr_ld) begin
      m_ip = ld_ip; m_dp = ld_dp; m_op = ld_op;
    end else if (acc && wt) begin
      m_ip = ins_addr; m_op = ins_opcode;
      if (ins_has_mem) m_dp = ins_opnd;
    end
    if (clr) begin
      m_flags = 0; m_es = 0; m_cause = 3'd7;
    end else if (exc_valid) begin
      m_flags |= exc_cond;
      if (unm != 0) begin
        if (!m_es) m_cause = first_set(unm);
        m_es = 1;
      end
    end
    m_trap = wt && !acc;
    if (cw_wr) m_mask = cw_mask;
    if (init) m_mask = 6'h3F;
    @(posedge clk);
    @(negedge clk);
    check_all();
    idle();
  endtask

  task automatic issue(input logic [2:0] k, input logic [AW-1:0] a, input logic mem,
                       input logic [AW-1:0] d, input logic [OW-1:0] o);
    ins_valid = 1; ins_kind = k; ins_addr = a; ins_has_mem = mem; ins_opnd = d; ins_opcode = o;
    tick();
  endtask

  task automatic raise(input logic [5:0] c);
    exc_valid = 1; exc_cond = c;
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    idle();
    m_ip = 0; m_dp = 0; m_op = 0; m_flags = 0; m_mask = 6'h3F;
    m_es = 0; m_trap = 0; m_cause = 3'd7;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all();                                   // R10 reset state

    issue(3'd0, 20'h1A2B3, 1, 20'h0FF00, 11'h2D5);   // R1 R2 capture with operand
    issue(3'd1, 20'h00404, 0, 20'h55555, 11'h0F0);   // R2 no operand, dp kept
    raise(6'b000101);                               // R4 masked: flags only
    cw_wr = 1; cw_mask = 6'b000000; tick();         // R11
    raise(6'b011010);                               // R5 cause 1
    raise(6'b000001);                               // R5 cause held
    issue(3'd0, 20'h77777, 1, 20'h12121, 11'h111);  // R6 trap, R8 frozen
    issue(3'd4, 20'h88888, 1, 20'h23232, 11'h222);  // R7 store status exempt
    issue(3'd5, 20'h99999, 1, 20'h34343, 11'h333);  // R7
    issue(3'd1, 20'hAAAAA, 0, 20'h0, 11'h444);      // R6 nop traps
    ptr_ld = 1; ld_ip = 20'hBEEF1; ld_dp = 20'hCAFE2; ld_op = 11'h5A5; tick(); // R12
    ins_valid = 1; ins_kind = 3'd3; exc_valid = 1; exc_cond = 6'h3F; tick();  // R9 clear wins
    ptr_ld = 1; ld_ip = 20'h1; ld_dp = 20'h2; ld_op = 11'h3;
    ins_valid = 1; ins_kind = 3'd0; ins_addr = 20'h4; ins_has_mem = 1; ins_opnd = 20'h5;
    ins_opcode = 11'h6; tick();                     // R12 load beats capture
    raise(6'b100000);                               // precision only, unmasked
    cw_wr = 1; cw_mask = 6'h00; ins_valid = 1; ins_kind = 3'd2; tick(); // R10 R11 init wins
    issue(3'd7, 20'hF0F0F, 1, 20'h0A0A0, 11'h7FF);  // reserved kind waits, R1

    for (int n = 0; n < 1500; n++) begin
      int r;
      r = $urandom % 8;
      if (r < 4) begin
        logic [2:0] k;
        k = 3'($urandom);
        if ((k == 3'd2 || k == 3'd3) && ($urandom % 4) != 0) k = 3'd0;
        issue(k, AW'($urandom), 1'($urandom), AW'($urandom), OW'($urandom));
      end else if (r < 6) begin
        raise(6'($urandom) & 6'($urandom));
      end else if (r == 6) begin
        cw_wr = 1; cw_mask = 6'($urandom); tick();
      end else if (($urandom % 3) == 0) begin
        ptr_ld = 1; ld_ip = AW'($urandom); ld_dp = AW'($urandom); ld_op = OW'($urandom); tick();
      end else begin
        tick();
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule